// File: doc/BRIEF.md
# Indirect Register Access Bridge

The bridge lets a host reach the handful of internal registers of a two-wire bus controller through a single 64-bit command word. The host writes a command word with its go bit set. The word carries an operation form, a register selector, a read flag and a data byte. The bridge runs exactly one internal access and drops the go bit when that access is finished. The host polls the word until the go bit reads zero. On a read, the low byte of the word then holds the value that was fetched. The bus engine sits outside this block. The bridge gives the engine a one-cycle write or read strobe with the selector and the byte, and it takes in the engine's data, control and status bytes.

The two clock-divider settings are held inside the bridge: the clock high-period count and the clock-control byte. A soft-reset access pulses a reset line to the engine and leaves both settings as they are. A second, plain host register holds three bits. Two of them override the clock line and the data line by hand. The third enables an interrupt that stays raised while the engine status is anything but the idle code.

Top module: `irb_bridge`

## Requirements
- R1: After reset the command word and the override word read 0, the clock high-period count reads 0x18, the clock-control byte reads 0x10, and all strobes and `irq` are low.
- R2: A command-port write with bit 63 set is accepted on that edge, so bit 63 reads 1 right after it. Bit 63 stays 1 for exactly 2 cycles (parameter `ACC_LAT`). Any strobe is high for one cycle only, the second of those cycles. Bit 63 reads 0 in the cycle after the strobe.
- R3: A command-port write with bit 63 clear is stored as written and starts no access: no strobe is raised and bit 63 stays 0.
- R4: The extended form is bits 59 and 58 both set, with the selector in bits 34:32. An extended write (bit 56 clear) to selector 1 (data) or selector 2 (control) raises `eng_wr` for one cycle. During that cycle `eng_sel` carries the selector and `eng_wdata` carries bits 7:0.
- R5: An extended read (bit 56 set) raises `eng_rd` for one cycle. At completion it puts `eng_data_q` (selector 1), `eng_ctl_q` (selector 2) or `eng_stat_q` (selector 3) into bits 7:0 and keeps bits 62:8 as written.
- R6: An extended write to selector 3 loads bits 7:0 into `clk_ctl` at completion and raises no engine strobe.
- R7: The plain form is bit 59 set, bit 58 clear and selector 0. A plain write loads bits 7:0 into `clk_hi`. A plain read returns `clk_hi` in bits 7:0.
- R8: An extended write to selector 7 raises `eng_srst` for one cycle and leaves `clk_hi` and `clk_ctl` unchanged.
- R9: A command-port write that arrives while bit 63 is still 1 is ignored. The running access completes with its own word and its own effects.
- R10: Every other combination (selectors 0, 4, 5 and 6 in the extended form, an extended read of selector 7, the plain form with a non-zero selector, and bit 59 clear) completes with the normal timing and raises no strobe. A read of this kind returns 0 in bits 7:0, and a write leaves bits 7:0 as written.
- R11: Override-port bit 6 enables the interrupt. `irq` is high exactly when that bit is set and `eng_stat_q` differs from 0xF8.
- R12: Override-port bit 9 drives `scl_ovr` and bit 8 drives `sda_ovr`. The override word reads back only bits 9, 8 and 6, with every other bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_we | input | 1 | Host write strobe |
| host_sel | input | 1 | Host target: 0 command word, 1 override word |
| host_wdata | input | 64 | Host write data |
| cmd_word | output | 64 | Command word readback |
| ovr_word | output | 64 | Override word readback |
| irq | output | 1 | Non-idle status interrupt |
| scl_ovr | output | 1 | Manual clock-line override |
| sda_ovr | output | 1 | Manual data-line override |
| eng_wr | output | 1 | Engine register write strobe |
| eng_rd | output | 1 | Engine register read strobe |
| eng_srst | output | 1 | Engine soft-reset pulse |
| eng_sel | output | 3 | Engine register selector |
| eng_wdata | output | 8 | Engine write byte |
| eng_data_q | input | 8 | Engine data register value |
| eng_ctl_q | input | 8 | Engine control register value |
| eng_stat_q | input | 8 | Engine status value |
| clk_hi | output | 8 | Clock high-period count |
| clk_ctl | output | 8 | Clock-control byte |

## Verification
The bench sweeps every operation form (both form bits), every selector and both directions, each with three data bytes. A selector whose meaning changes with the direction therefore shows up as a clock-control update on a write and as the status byte on a read. Engine inputs are changed with every command, so a read that returns the wrong register, or that returns stale data, does not match. Clock writes land before the soft-reset sweep, so a reset that disturbs the settings is visible. Separate cases write a second command at the capture edge of a busy access, store a word with the go bit clear, and sweep all 256 status codes with the interrupt enabled and disabled.

// File: rtl/irb_pkg.sv
package irb_pkg;

  localparam int CMD_W     = 64;
  localparam int BYTE_W    = 8;
  localparam int SEL_W     = 3;
  localparam int GO_BIT    = 63;
  localparam int OPA_BIT   = 59;
  localparam int OPB_BIT   = 58;
  localparam int RD_BIT    = 56;
  localparam int SEL_LSB   = 32;

  localparam int OVR_SCL_BIT = 9;
  localparam int OVR_SDA_BIT = 8;
  localparam int OVR_IEN_BIT = 6;

  localparam logic [SEL_W-1:0] SEL_CLKHI   = 3'd0;
  localparam logic [SEL_W-1:0] SEL_DATA    = 3'd1;
  localparam logic [SEL_W-1:0] SEL_CTRL    = 3'd2;
  localparam logic [SEL_W-1:0] SEL_CLKSTAT = 3'd3;
  localparam logic [SEL_W-1:0] SEL_SRST    = 3'd7;

  typedef enum logic [2:0] {
    K_NONE,
    K_ENG_WR,
    K_ENG_RD,
    K_CLKHI_WR,
    K_CLKHI_RD,
    K_CLKCTL_WR,
    K_SRST
  } acc_kind_e;

endpackage

// File: rtl/irb_decode.sv
module irb_decode
  import irb_pkg::*;
(
  input  logic [1:0]       op,
  input  logic             rd,
  input  logic [SEL_W-1:0] sel,
  output acc_kind_e        kind
);

  logic ext_form;
  logic plain_form;

  always_comb begin
    ext_form   = (op == 2'b11);
    plain_form = (op == 2'b10) && (sel == SEL_CLKHI);
  end

  always_comb begin
    kind = K_NONE;
    if (ext_form) begin
      if (rd) begin
        if ((sel == SEL_DATA) || (sel == SEL_CTRL) || (sel == SEL_CLKSTAT))
          kind = K_ENG_RD;
      end else begin
        case (sel)
          SEL_DATA,
          SEL_CTRL:    kind = K_ENG_WR;
          SEL_CLKSTAT: kind = K_CLKCTL_WR;
          SEL_SRST:    kind = K_SRST;
          default:     kind = K_NONE;
        endcase
      end
    end else if (plain_form) begin
      kind = rd ? K_CLKHI_RD : K_CLKHI_WR;
    end
  end

endmodule

// File: rtl/irb_seq.sv
module irb_seq #(
  parameter int LAT = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy,
  output logic fire
);

  localparam int CW = $clog2(LAT + 1);
  localparam logic [CW-1:0] LAST = CW'(LAT - 1);

  typedef enum logic {S_IDLE, S_RUN} seq_st_e;

  seq_st_e        st_q, st_d;
  logic [CW-1:0]  cnt_q, cnt_d;
  logic           cnt_en;

  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    cnt_en = 1'b0;
    fire   = 1'b0;
    case (st_q)
      S_IDLE: begin
        if (start) begin
          st_d   = S_RUN;
          cnt_d  = '0;
          cnt_en = 1'b1;
        end
      end
      S_RUN: begin
        if (cnt_q == LAST) begin
          fire = 1'b1;
          st_d = S_IDLE;
        end else begin
          cnt_d  = cnt_q + CW'(1);
          cnt_en = 1'b1;
        end
      end
      default: st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= S_IDLE;
    end else begin
      st_q <= st_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  always_comb busy = (st_q == S_RUN);

endmodule

// File: rtl/irb_cfg.sv
module irb_cfg
  import irb_pkg::*;
#(
  parameter logic [BYTE_W-1:0] CLK_HI_RST  = 8'h18,
  parameter logic [BYTE_W-1:0] CLK_CTL_RST = 8'h10,
  parameter logic [BYTE_W-1:0] IDLE_CODE   = 8'hF8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clkhi_we,
  input  logic              clkctl_we,
  input  logic [BYTE_W-1:0] wbyte,
  input  logic              ovr_we,
  input  logic              ovr_scl_in,
  input  logic              ovr_sda_in,
  input  logic              ovr_ien_in,
  input  logic [BYTE_W-1:0] stat_in,
  output logic [BYTE_W-1:0] clk_hi,
  output logic [BYTE_W-1:0] clk_ctl,
  output logic [CMD_W-1:0]  ovr_word,
  output logic              scl_ovr,
  output logic              sda_ovr,
  output logic              irq
);

  logic [BYTE_W-1:0] clk_hi_q, clk_ctl_q;
  logic [2:0]        ovr_q, ovr_d;

  always_comb ovr_d = {ovr_scl_in, ovr_sda_in, ovr_ien_in};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clk_hi_q <= CLK_HI_RST;
    end else if (clkhi_we) begin
      clk_hi_q <= wbyte;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clk_ctl_q <= CLK_CTL_RST;
    end else if (clkctl_we) begin
      clk_ctl_q <= wbyte;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovr_q <= '0;
    end else if (ovr_we) begin
      ovr_q <= ovr_d;
    end
  end

  always_comb begin
    ovr_word              = '0;
    ovr_word[OVR_SCL_BIT] = ovr_q[2];
    ovr_word[OVR_SDA_BIT] = ovr_q[1];
    ovr_word[OVR_IEN_BIT] = ovr_q[0];
    scl_ovr               = ovr_q[2];
    sda_ovr               = ovr_q[1];
    irq                   = ovr_q[0] && (stat_in != IDLE_CODE);
    clk_hi                = clk_hi_q;
    clk_ctl               = clk_ctl_q;
  end

endmodule

// File: rtl/irb_bridge.sv
module irb_bridge
  import irb_pkg::*;
#(
  parameter int                ACC_LAT     = 2,
  parameter logic [BYTE_W-1:0] CLK_HI_RST  = 8'h18,
  parameter logic [BYTE_W-1:0] CLK_CTL_RST = 8'h10,
  parameter logic [BYTE_W-1:0] IDLE_CODE   = 8'hF8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_we,
  input  logic              host_sel,
  input  logic [CMD_W-1:0]  host_wdata,
  output logic [CMD_W-1:0]  cmd_word,
  output logic [CMD_W-1:0]  ovr_word,
  output logic              irq,
  output logic              scl_ovr,
  output logic              sda_ovr,
  output logic              eng_wr,
  output logic              eng_rd,
  output logic              eng_srst,
  output logic [SEL_W-1:0]  eng_sel,
  output logic [BYTE_W-1:0] eng_wdata,
  input  logic [BYTE_W-1:0] eng_data_q,
  input  logic [BYTE_W-1:0] eng_ctl_q,
  input  logic [BYTE_W-1:0] eng_stat_q,
  output logic [BYTE_W-1:0] clk_hi,
  output logic [BYTE_W-1:0] clk_ctl
);

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rs_q;
  logic       rst_i_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_q <= 2'b00;
    end else begin
      rs_q <= {rs_q[0], 1'b1};
    end
  end

  always_comb rst_i_n = rs_q[1];

  // command word
  logic [CMD_W-1:0]  cmd_q, cmd_d;
  logic              cmd_en;
  logic              cmd_take;
  logic              start;
  logic              busy;
  logic              fire;
  acc_kind_e         kind;
  logic [BYTE_W-1:0] rd_byte;
  logic [SEL_W-1:0]  sel_f;
  logic [BYTE_W-1:0] byte_f;

  always_comb begin
    sel_f    = cmd_q[SEL_LSB +: SEL_W];
    byte_f   = cmd_q[BYTE_W-1:0];
    cmd_take = host_we && !host_sel && !cmd_q[GO_BIT];
    start    = cmd_take && host_wdata[GO_BIT];
  end

  irb_decode u_dec (
    .op   ({cmd_q[OPA_BIT], cmd_q[OPB_BIT]}),
    .rd   (cmd_q[RD_BIT]),
    .sel  (sel_f),
    .kind (kind)
  );

  irb_seq #(.LAT(ACC_LAT)) u_seq (
    .clk   (clk),
    .rst_n (rst_i_n),
    .start (start),
    .busy  (busy),
    .fire  (fire)
  );

  always_comb begin
    case (kind)
      K_ENG_RD: begin
        case (sel_f)
          SEL_DATA: rd_byte = eng_data_q;
          SEL_CTRL: rd_byte = eng_ctl_q;
          default:  rd_byte = eng_stat_q;
        endcase
      end
      K_CLKHI_RD: rd_byte = clk_hi;
      default:    rd_byte = '0;
    endcase
  end

  always_comb begin
    cmd_d  = cmd_q;
    cmd_en = 1'b0;
    if (fire) begin
      cmd_en        = 1'b1;
      cmd_d[GO_BIT] = 1'b0;
      if (cmd_q[RD_BIT])
        cmd_d[BYTE_W-1:0] = rd_byte;
    end else if (cmd_take) begin
      cmd_en = 1'b1;
      cmd_d  = host_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      cmd_q <= '0;
    end else if (cmd_en) begin
      cmd_q <= cmd_d;
    end
  end

  // engine strobes
  always_comb begin
    eng_wr    = fire && (kind == K_ENG_WR);
    eng_rd    = fire && (kind == K_ENG_RD);
    eng_srst  = fire && (kind == K_SRST);
    eng_sel   = sel_f;
    eng_wdata = byte_f;
    cmd_word  = cmd_q;
  end

  irb_cfg #(
    .CLK_HI_RST  (CLK_HI_RST),
    .CLK_CTL_RST (CLK_CTL_RST),
    .IDLE_CODE   (IDLE_CODE)
  ) u_cfg (
    .clk        (clk),
    .rst_n      (rst_i_n),
    .clkhi_we   (fire && (kind == K_CLKHI_WR)),
    .clkctl_we  (fire && (kind == K_CLKCTL_WR)),
    .wbyte      (byte_f),
    .ovr_we     (host_we && host_sel),
    .ovr_scl_in (host_wdata[OVR_SCL_BIT]),
    .ovr_sda_in (host_wdata[OVR_SDA_BIT]),
    .ovr_ien_in (host_wdata[OVR_IEN_BIT]),
    .stat_in    (eng_stat_q),
    .clk_hi     (clk_hi),
    .clk_ctl    (clk_ctl),
    .ovr_word   (ovr_word),
    .scl_ovr    (scl_ovr),
    .sda_ovr    (sda_ovr),
    .irq        (irq)
  );

endmodule

// File: rtl/irb_bridge_chk.sv
module irb_bridge_chk #(
  parameter int LAT = 2
) (
  input logic        clk,
  input logic        rst_n,
  input logic        host_we,
  input logic        host_sel,
  input logic        host_go,
  input logic        cmd_valid,
  input logic [54:0] cmd_mid,
  input logic [7:0]  clk_hi,
  input logic [7:0]  clk_ctl,
  input logic        eng_wr,
  input logic        eng_rd,
  input logic        eng_srst,
  input logic [7:0]  eng_stat_q,
  input logic        irq
);

  logic [7:0] age_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      age_q <= '0;
    end else if (!cmd_valid) begin
      age_q <= '0;
    end else if (age_q != 8'hFF) begin
      age_q <= age_q + 8'd1;
    end
  end

  // R2: go bit never outlives the access window
  a_r2_valid_window: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> (age_q < 8'(LAT)));

  // R2: strobes only in the last busy cycle
  a_r2_strobe_last: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_wr || eng_rd || eng_srst) |-> (cmd_valid && (age_q == 8'(LAT - 1))));

  // R2: one strobe at a time
  a_r2_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({eng_wr, eng_rd, eng_srst}));

  // R3: a word without the go bit launches nothing
  a_r3_no_launch: assert property (@(posedge clk) disable iff (!rst_n)
    (host_we && !host_sel && !cmd_valid && !host_go) |=> !cmd_valid);

  // R9: a write while busy leaves the stored word intact
  a_r9_busy_ignore: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && host_we && !host_sel) |=> (cmd_mid == $past(cmd_mid)));

  // R8: soft reset keeps the clock settings
  a_r8_srst_keeps_clk: assert property (@(posedge clk) disable iff (!rst_n)
    eng_srst |=> ($stable(clk_hi) && $stable(clk_ctl)));

  // R11: idle status never interrupts
  a_r11_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_stat_q == 8'hF8) |-> !irq);

endmodule

bind irb_bridge irb_bridge_chk #(.LAT(ACC_LAT)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .host_we    (host_we),
  .host_sel   (host_sel),
  .host_go    (host_wdata[63]),
  .cmd_valid  (cmd_word[63]),
  .cmd_mid    (cmd_word[62:8]),
  .clk_hi     (clk_hi),
  .clk_ctl    (clk_ctl),
  .eng_wr     (eng_wr),
  .eng_rd     (eng_rd),
  .eng_srst   (eng_srst),
  .eng_stat_q (eng_stat_q),
  .irq        (irq)
);

// File: tb/tb_irb_bridge.sv
module tb_irb_bridge;

  localparam int CLK_PERIOD = 10;
  localparam int LAT        = 2;

  logic        clk;
  logic        rst_n;
  logic        host_we;
  logic        host_sel;
  logic [63:0] host_wdata;
  logic [63:0] cmd_word;
  logic [63:0] ovr_word;
  logic        irq, scl_ovr, sda_ovr;
  logic        eng_wr, eng_rd, eng_srst;
  logic [2:0]  eng_sel;
  logic [7:0]  eng_wdata;
  logic [7:0]  e_data, e_ctl, e_stat;
  logic [7:0]  clk_hi, clk_ctl;

  int n_chk;
  int n_bad;
  logic [7:0] m_clk_hi;
  logic [7:0] m_clk_ctl;

  irb_bridge #(.ACC_LAT(LAT)) dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .host_we    (host_we),
    .host_sel   (host_sel),
    .host_wdata (host_wdata),
    .cmd_word   (cmd_word),
    .ovr_word   (ovr_word),
    .irq        (irq),
    .scl_ovr    (scl_ovr),
    .sda_ovr    (sda_ovr),
    .eng_wr     (eng_wr),
    .eng_rd     (eng_rd),
    .eng_srst   (eng_srst),
    .eng_sel    (eng_sel),
    .eng_wdata  (eng_wdata),
    .eng_data_q (e_data),
    .eng_ctl_q  (e_ctl),
    .eng_stat_q (e_stat),
    .clk_hi     (clk_hi),
    .clk_ctl    (clk_ctl)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic check(input bit ok, input string req,
                       input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic put(input logic sel, input logic [63:0] w);
    @(negedge clk);
    host_we    = 1'b1;
    host_sel   = sel;
    host_wdata = w;
    @(negedge clk);
    host_we    = 1'b0;
  endtask

  task automatic run_txn(input logic [1:0] f, input logic rd,
                         input logic [2:0] sel, input logic [7:0] d);
    logic [63:0] w;
    logic        ext, plain, x_wr, x_rd, x_srst;
    logic [7:0]  x_byte;
    string       tag;
    w      = {1'b1, 3'b000, f, 1'b0, rd, 21'h0A5C3, sel, 24'hB1E7D2, d};
    ext    = (f == 2'b11);
    plain  = (f == 2'b10) && (sel == 3'd0);
    x_wr   = ext && !rd && (sel == 3'd1 || sel == 3'd2);
    x_rd   = ext && rd && (sel >= 3'd1 && sel <= 3'd3);
    x_srst = ext && !rd && (sel == 3'd7);
    if (x_wr)                      tag = "R4";
    else if (x_rd)                 tag = "R5";
    else if (ext && !rd && sel == 3'd3) tag = "R6";
    else if (plain)                tag = "R7";
    else if (x_srst)               tag = "R8";
    else                           tag = "R10";
    e_data = d ^ 8'h3C;
    e_ctl  = d ^ 8'hC3;
    e_stat = d + 8'd1;
    if (!rd)                      x_byte = d;
    else if (ext && sel == 3'd1)  x_byte = e_data;
    else if (ext && sel == 3'd2)  x_byte = e_ctl;
    else if (ext && sel == 3'd3)  x_byte = e_stat;
    else if (plain)               x_byte = m_clk_hi;
    else                          x_byte = 8'h00;
    put(1'b0, w);
    check(cmd_word[63] == 1'b1, "R2 go set", {63'd0, cmd_word[63]}, 64'd1);
    check({eng_wr, eng_rd, eng_srst} == 3'b000, "R2 no early strobe",
          {61'd0, eng_wr, eng_rd, eng_srst}, 64'd0);
    @(negedge clk);
    check(cmd_word[63] == 1'b1, "R2 go held", {63'd0, cmd_word[63]}, 64'd1);
    check({eng_wr, eng_rd, eng_srst} == {x_wr, x_rd, x_srst}, tag,
          {61'd0, eng_wr, eng_rd, eng_srst}, {61'd0, x_wr, x_rd, x_srst});
    if (x_wr)
      check({eng_sel, eng_wdata} == {sel, d}, "R4 sel/byte",
            {53'd0, eng_sel, eng_wdata}, {53'd0, sel, d});
    if (ext && !rd && sel == 3'd3) m_clk_ctl = d;
    if (plain && !rd)              m_clk_hi  = d;
    @(negedge clk);
    check(cmd_word == {1'b0, w[62:8], x_byte}, tag, cmd_word,
          {1'b0, w[62:8], x_byte});
    check({clk_hi, clk_ctl} == {m_clk_hi, m_clk_ctl}, "R6 R7 R8 clock regs",
          {48'd0, clk_hi, clk_ctl}, {48'd0, m_clk_hi, m_clk_ctl});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL R2 watchdog act=hung exp=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [63:0] wa, wb;
    n_chk      = 0;
    n_bad      = 0;
    m_clk_hi   = 8'h18;
    m_clk_ctl  = 8'h10;
    rst_n      = 1'b0;
    host_we    = 1'b0;
    host_sel   = 1'b0;
    host_wdata = '0;
    e_data     = 8'h00;
    e_ctl      = 8'h00;
    e_stat     = 8'h55;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1
    check(cmd_word == 64'd0, "R1 cmd", cmd_word, 64'd0);
    check(ovr_word == 64'd0, "R1 ovr", ovr_word, 64'd0);
    check({clk_hi, clk_ctl} == 16'h1810, "R1 clock", {48'd0, clk_hi, clk_ctl}, 64'h1810);
    check({eng_wr, eng_rd, eng_srst, irq} == 4'd0, "R1 strobes",
          {60'd0, eng_wr, eng_rd, eng_srst, irq}, 64'd0);

    // sweep: R2 R4 R5 R6 R7 R8 R10
    for (int f = 0; f < 4; f++)
      for (int s = 0; s < 8; s++)
        for (int r = 0; r < 2; r++)
          for (int k = 0; k < 3; k++)
            run_txn(2'(f), 1'(r), 3'(s), (k == 0) ? 8'h00 : (k == 1) ? 8'hFF : 8'h96);

    // R3: go bit clear stores the word only
    wa = 64'h0C00_0001_0000_00A7;
    put(1'b0, wa);
    for (int i = 0; i < 3; i++) begin
      check(cmd_word == wa, "R3 stored", cmd_word, wa);
      check(eng_wr == 1'b0, "R3 no strobe", {63'd0, eng_wr}, 64'd0);
      @(negedge clk);
    end

    // R9: second command on the capture edge of a busy access
    e_ctl = 8'h6B;
    wa = 64'h8D00_0002_1234_5600;
    wb = 64'h8800_0000_0000_0077;
    put(1'b0, wa);
    host_we    = 1'b1;
    host_sel   = 1'b0;
    host_wdata = wb;
    @(negedge clk);
    host_we = 1'b0;
    @(negedge clk);
    check(cmd_word == {1'b0, wa[62:8], 8'h6B}, "R9 word kept", cmd_word,
          {1'b0, wa[62:8], 8'h6B});
    check(clk_hi == m_clk_hi, "R9 no clock write", {56'd0, clk_hi}, {56'd0, m_clk_hi});

    // R12
    put(1'b1, 64'hFFFF_FFFF_FFFF_FFFF);
    check(ovr_word == 64'h340, "R12 mask", ovr_word, 64'h340);
    check({scl_ovr, sda_ovr} == 2'b11, "R12 both", {62'd0, scl_ovr, sda_ovr}, 64'd3);
    put(1'b1, 64'h200);
    check({scl_ovr, sda_ovr} == 2'b10, "R12 clock line", {62'd0, scl_ovr, sda_ovr}, 64'd2);
    put(1'b1, 64'h100);
    check({scl_ovr, sda_ovr} == 2'b01, "R12 data line", {62'd0, scl_ovr, sda_ovr}, 64'd1);

    // R11: all status codes, enabled and disabled
    for (int en = 0; en < 2; en++) begin
      put(1'b1, en ? 64'h40 : 64'h0);
      for (int st = 0; st < 256; st++) begin
        e_stat = 8'(st);
        #1;
        check(irq == ((en == 1) && (st != 8'hF8)), "R11 irq",
              {63'd0, irq}, {63'd0, ((en == 1) && (st != 8'hF8))});
      end
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule